// File: doc/BRIEF.md
# Boundary-Scan Self-Test Pattern Engine

This block drives the test-mode data path of a scan-testable bidirectional transceiver built from two 9-bit byte lanes, each with an A-side and a B-side pin group. That gives 36 data boundary cells. A 3-bit opcode picks one of five self-test operations: sample inputs while toggling outputs, a 36-bit pseudorandom pattern generator, a 36-bit parallel signature register, and two split 18-bit modes. The split modes pair a signature half with either a pattern half or a binary up-counter half. The chosen operation moves on each rising test-clock edge, but only while the run qualifier is high, meaning the run-test instruction is loaded and the TAP controller is in Run-Test/Idle.

The four direction enables decide which pin group of each lane receives and which one drives. Every operation runs only when each lane drives in exactly one direction and both lanes agree on that direction. In any other case the engine behaves as bypass and the cells hold their value. On every falling edge the shift-cell contents are copied into shadow latches, and those latches present the values at the pins. The output-enable pattern comes straight from the direction enables in every mode.

Cell layout: bits 8:0 are lane 0 on the A side, 17:9 are lane 1 on the A side, 26:18 are lane 0 on the B side, and 35:27 are lane 1 on the B side. The "A half" is bits 17:0 and the "B half" is bits 35:18. When the engine runs with `ab_en` = 2'b11, the A half is the input half and the B half is the output half. With `ba_en` = 2'b11 the roles swap. The pin data and control inputs are plain level signals sampled at the clock edge. They carry no stream, so the block has no valid/ready handshake.

Top module: `bst_selftest_engine`

## Requirements
- R1: While `rst_n` is low, `cell_q` and `pin_out` are all zero.
- R2: The cells change on a rising edge only when `engine_on` is high. `engine_on` is high when `run_idle` is 1, `ab_en[k] != ba_en[k]` for both lanes, and `ab_en[0] == ab_en[1]`. In every other case `cell_q` keeps its value.
- R3: Opcode with bits 1:0 = 00 (bit 2 ignored) is toggle/sample. The input half loads the matching input-half bits of `pin_in`. The output half inverts.
- R4: Opcode with bits 1:0 = 01 is the 36-bit generator. For a nonzero state s, the next state is (s >> 1), XORed with a mask having bits 35 and 10 set when s[0] = 1.
- R5: Any pattern-generator half or register whose state is all zero loads the value 1 (bit 0 set) on the next advancing edge.
- R6: Opcode with bits 1:0 = 10 is the 36-bit signature register. The next state is the R4 step of the current state, XORed with all 36 bits of `pin_in`.
- R7: Opcode 011 splits the register into two 18-bit halves. The input half takes the 18-bit step (mask bits 17 and 6), XORed with its own `pin_in` bits. The output half runs the 18-bit generator with the R5 rule.
- R8: Opcode 111 updates the input half as in R7. The output half adds 1, wrapping from 2^18-1 to 0.
- R9: On each falling edge, `pin_out` takes the value of `cell_q`.
- R10: `pin_oe` is high on A-side lane k bits when `ba_en[k]` is 1 and on B-side lane k bits when `ab_en[k]` is 1. This holds in every mode, including bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock. Cells update on the rising edge, shadows on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_idle | input | 1 | High while the run-test instruction is active in Run-Test/Idle |
| opcode | input | 3 | Self-test operation select |
| ab_en | input | 2 | A-to-B drive enable per lane |
| ba_en | input | 2 | B-to-A drive enable per lane |
| pin_in | input | 36 | Data observed at the 36 pins |
| cell_q | output | 36 | Shift-cell contents |
| pin_out | output | 36 | Shadow-latch values presented to the pins |
| pin_oe | output | 36 | Per-pin drive enable |
| engine_on | output | 1 | Selected operation advances on this edge |

## Verification
The checker relies on four assumptions about the inputs:
- `opcode`, the direction enables and `run_idle` change only away from the rising edge.
- Each of them stays level across the edge on which it is sampled.
- The reset is the only asynchronous input.
- The expected half roles follow `ab_en[0]` whenever the engine is on.

The stimulus respects this by changing every input one step after a falling edge, so each input is stable through the following rising edge. It sweeps both traffic directions, the invalid and mismatched enable mixes, and opcodes with bit 2 set where that bit is a don't-care.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic [2:0] {
    MD_TOGGLE   = 3'd0,
    MD_PRPG     = 3'd1,
    MD_PSA      = 3'd2,
    MD_PSA_PRPG = 3'd3,
    MD_PSA_CNT  = 3'd4
  } mode_e;

  function automatic mode_e decode_op(input logic [2:0] op);
    mode_e m;
    unique case (op[1:0])
      2'b00: m = MD_TOGGLE;
      2'b01: m = MD_PRPG;
      2'b10: m = MD_PSA;
      default: m = op[2] ? MD_PSA_CNT : MD_PSA_PRPG;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bst_dir_guard.sv
module bst_dir_guard #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic [LANES-1:0]          ab_en,
  input  logic [LANES-1:0]          ba_en,
  output logic                      dir_ok,
  output logic                      a_to_b,
  output logic [2*LANES*LANE_W-1:0] oe
);
  localparam int SIDE = LANES * LANE_W;

  logic [LANES-1:0] lane_single;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_single[l]            = ab_en[l] ^ ba_en[l];
    assign oe[l*LANE_W +: LANE_W]    = {LANE_W{ba_en[l]}};
    assign oe[SIDE + l*LANE_W +: LANE_W] = {LANE_W{ab_en[l]}};
  end

  logic lanes_agree;
  assign lanes_agree = (&ab_en) | (~|ab_en);
  assign dir_ok      = (&lane_single) & lanes_agree;
  assign a_to_b      = ab_en[0];
endmodule

// File: rtl/bst_cell_engine.sv
module bst_cell_engine
  import bst_pkg::*;
#(
  parameter int LANE_W   = 9,
  parameter int TAP_FULL = 11,
  parameter int TAP_HALF = 7
) (
  input  logic                  tck,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic                  a_to_b,
  input  mode_e                 mode,
  input  logic [4*LANE_W-1:0]   pin_in,
  output logic [4*LANE_W-1:0]   cell_q
);
  localparam int CELLS = 4 * LANE_W;
  localparam int HALF  = 2 * LANE_W;
  localparam logic [CELLS-1:0] FULL_MASK =
    (CELLS'(1) << (CELLS-1)) | (CELLS'(1) << (TAP_FULL-1));
  localparam logic [HALF-1:0] HALF_MASK =
    (HALF'(1) << (HALF-1)) | (HALF'(1) << (TAP_HALF-1));

  function automatic logic [CELLS-1:0] step_full(input logic [CELLS-1:0] s);
    return (s >> 1) ^ (s[0] ? FULL_MASK : '0);
  endfunction

  function automatic logic [HALF-1:0] step_half(input logic [HALF-1:0] s);
    return (s >> 1) ^ (s[0] ? HALF_MASK : '0);
  endfunction

  logic [HALF-1:0]  in_half, out_half, pin_half;
  logic [HALF-1:0]  in_nxt, out_nxt;
  logic [CELLS-1:0] full_nxt, cell_nxt;
  logic             use_full;

  always_comb begin
    in_half  = a_to_b ? cell_q[HALF-1:0]  : cell_q[CELLS-1:HALF];
    out_half = a_to_b ? cell_q[CELLS-1:HALF] : cell_q[HALF-1:0];
    pin_half = a_to_b ? pin_in[HALF-1:0]  : pin_in[CELLS-1:HALF];
    in_nxt   = in_half;
    out_nxt  = out_half;
    full_nxt = cell_q;
    use_full = 1'b0;
    unique case (mode)
      MD_TOGGLE: begin
        in_nxt  = pin_half;
        out_nxt = ~out_half;
      end
      MD_PRPG: begin
        use_full = 1'b1;
        full_nxt = (cell_q == '0) ? CELLS'(1) : step_full(cell_q);
      end
      MD_PSA: begin
        use_full = 1'b1;
        full_nxt = step_full(cell_q) ^ pin_in;
      end
      MD_PSA_PRPG: begin
        in_nxt  = step_half(in_half) ^ pin_half;
        out_nxt = (out_half == '0) ? HALF'(1) : step_half(out_half);
      end
      MD_PSA_CNT: begin
        in_nxt  = step_half(in_half) ^ pin_half;
        out_nxt = out_half + HALF'(1);
      end
      default: ;
    endcase
    if (use_full)    cell_nxt = full_nxt;
    else if (a_to_b) cell_nxt = {out_nxt, in_nxt};
    else             cell_nxt = {in_nxt, out_nxt};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       cell_q <= '0;
    else if (advance) cell_q <= cell_nxt;
  end
endmodule

// File: rtl/bst_shadow.sv
module bst_shadow #(
  parameter int WIDTH = 36
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/bst_selftest_engine.sv
module bst_selftest_engine
  import bst_pkg::*;
#(
  parameter int LANE_W   = 9,
  parameter int TAP_FULL = 11,
  parameter int TAP_HALF = 7
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                run_idle,
  input  logic [2:0]          opcode,
  input  logic [1:0]          ab_en,
  input  logic [1:0]          ba_en,
  input  logic [4*LANE_W-1:0] pin_in,
  output logic [4*LANE_W-1:0] cell_q,
  output logic [4*LANE_W-1:0] pin_out,
  output logic [4*LANE_W-1:0] pin_oe,
  output logic                engine_on
);
  localparam int LANES = 2;
  localparam int CELLS = 2 * LANES * LANE_W;

  logic  dir_ok, a_to_b;
  mode_e mode;

  assign mode      = decode_op(opcode);
  assign engine_on = run_idle & dir_ok;

  bst_dir_guard #(.LANE_W(LANE_W), .LANES(LANES)) u_guard (
    .ab_en (ab_en),
    .ba_en (ba_en),
    .dir_ok(dir_ok),
    .a_to_b(a_to_b),
    .oe    (pin_oe)
  );

  bst_cell_engine #(.LANE_W(LANE_W), .TAP_FULL(TAP_FULL), .TAP_HALF(TAP_HALF)) u_cells (
    .tck    (tck),
    .rst_n  (rst_n),
    .advance(engine_on),
    .a_to_b (a_to_b),
    .mode   (mode),
    .pin_in (pin_in),
    .cell_q (cell_q)
  );

  bst_shadow #(.WIDTH(CELLS)) u_shadow (
    .tck  (tck),
    .rst_n(rst_n),
    .d    (cell_q),
    .q    (pin_out)
  );
endmodule

// File: rtl/bst_selftest_checker.sv
module bst_selftest_checker #(
  parameter int LANE_W = 9
) (
  input logic                tck,
  input logic                rst_n,
  input logic [2:0]          opcode,
  input logic [1:0]          ab_en,
  input logic [1:0]          ba_en,
  input logic [4*LANE_W-1:0] cell_q,
  input logic [4*LANE_W-1:0] pin_out,
  input logic [4*LANE_W-1:0] pin_oe,
  input logic                engine_on
);
  localparam int CELLS = 4 * LANE_W;
  localparam int HALF  = 2 * LANE_W;

  logic [HALF-1:0] a_half, b_half;
  assign a_half = cell_q[HALF-1:0];
  assign b_half = cell_q[CELLS-1:HALF];

  a_r2_hold_when_off: assert property (@(posedge tck) disable iff (!rst_n)
    !engine_on |=> $stable(cell_q));

  a_r3_toggle_b_out: assert property (@(posedge tck) disable iff (!rst_n)
    (engine_on && opcode[1:0] == 2'b00 && ab_en[0]) |=> b_half == ~$past(b_half));

  a_r3_toggle_a_out: assert property (@(posedge tck) disable iff (!rst_n)
    (engine_on && opcode[1:0] == 2'b00 && !ab_en[0]) |=> a_half == ~$past(a_half));

  a_r5_prpg_nonzero: assert property (@(posedge tck) disable iff (!rst_n)
    (engine_on && opcode[1:0] == 2'b01) |=> cell_q != '0);

  a_r7_half_prpg_nonzero: assert property (@(posedge tck) disable iff (!rst_n)
    (engine_on && opcode == 3'b011 && ab_en[0]) |=> b_half != '0);

  a_r8_count_up: assert property (@(posedge tck) disable iff (!rst_n)
    (engine_on && opcode == 3'b111 && ab_en[0]) |=> b_half == $past(b_half) + HALF'(1));

  a_r9_shadow_follows: assert property (@(posedge tck) disable iff (!rst_n)
    pin_out == cell_q);

  a_r10_oe_b_side: assert property (@(posedge tck) disable iff (!rst_n)
    ($countones(pin_oe[CELLS-1:HALF]) == LANE_W * (int'(ab_en[0]) + int'(ab_en[1]))));

  a_r10_oe_a_side: assert property (@(posedge tck) disable iff (!rst_n)
    ($countones(pin_oe[HALF-1:0]) == LANE_W * (int'(ba_en[0]) + int'(ba_en[1]))));
endmodule

bind bst_selftest_engine bst_selftest_checker #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/bst_selftest_engine_test.sv
module bst_selftest_engine_test;
  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_idle = 1'b0;
  logic [2:0]  opcode = 3'b000;
  logic [1:0]  ab_en = 2'b11;
  logic [1:0]  ba_en = 2'b00;
  logic [35:0] pin_in = '0;
  logic [35:0] cell_q, pin_out, pin_oe;
  logic        engine_on;

  int n_checks = 0;
  int n_fail   = 0;
  logic [35:0] model = '0;

  always #2.5 tck = ~tck;

  bst_selftest_engine uut (
    .tck(tck), .rst_n(rst_n), .run_idle(run_idle), .opcode(opcode),
    .ab_en(ab_en), .ba_en(ba_en), .pin_in(pin_in), .cell_q(cell_q),
    .pin_out(pin_out), .pin_oe(pin_oe), .engine_on(engine_on)
  );

  // entry: {run, opcode[2:0], ab_en[1:0], ba_en[1:0], pin[35:0]}
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 3'b000, 2'b11, 2'b00, 36'h123456789},
    {1'b1, 3'b000, 2'b11, 2'b00, 36'hABCDEF012},
    {1'b1, 3'b001, 2'b11, 2'b00, 36'h000000000},
    {1'b1, 3'b001, 2'b11, 2'b00, 36'hFFFFFFFFF},
    {1'b1, 3'b010, 2'b11, 2'b00, 36'h0F0F0F0F0},
    {1'b1, 3'b010, 2'b11, 2'b00, 36'h5A5A5A5A5},
    {1'b1, 3'b011, 2'b11, 2'b00, 36'h3C3C3C3C3},
    {1'b1, 3'b011, 2'b11, 2'b00, 36'h987654321},
    {1'b1, 3'b111, 2'b11, 2'b00, 36'h000FF0000},
    {1'b1, 3'b111, 2'b11, 2'b00, 36'h111111111},
    {1'b0, 3'b001, 2'b11, 2'b00, 36'h222222222},
    {1'b1, 3'b001, 2'b01, 2'b10, 36'h333333333},
    {1'b1, 3'b001, 2'b11, 2'b11, 36'h444444444},
    {1'b1, 3'b100, 2'b00, 2'b11, 36'hC0FFEE123},
    {1'b1, 3'b011, 2'b00, 2'b11, 36'h7E7E7E7E7},
    {1'b1, 3'b111, 2'b00, 2'b11, 36'h0A0B0C0D0},
    {1'b1, 3'b110, 2'b00, 2'b11, 36'hDEADBEEF5},
    {1'b1, 3'b101, 2'b00, 2'b11, 36'h135792468}
  };

  function automatic logic [35:0] st36(logic [35:0] s);
    logic [35:0] r = {1'b0, s[35:1]};
    if (s[0]) begin r[35] = ~r[35]; r[10] = ~r[10]; end
    return r;
  endfunction

  function automatic logic [17:0] st18(logic [17:0] s);
    logic [17:0] r = {1'b0, s[17:1]};
    if (s[0]) begin r[17] = ~r[17]; r[6] = ~r[6]; end
    return r;
  endfunction

  function automatic logic dir_valid(logic [1:0] ab, logic [1:0] ba);
    return (ab[0] != ba[0]) && (ab[1] != ba[1]) && (ab[0] == ab[1]);
  endfunction

  function automatic logic [35:0] mnext(logic [35:0] c, logic run, logic [2:0] op,
                                        logic [1:0] ab, logic [1:0] ba, logic [35:0] pin);
    logic fwd = ab[0];
    logic [17:0] ih, oh, ip;
    if (!run || !dir_valid(ab, ba)) return c;
    ih = fwd ? c[17:0] : c[35:18];
    oh = fwd ? c[35:18] : c[17:0];
    ip = fwd ? pin[17:0] : pin[35:18];
    case (op[1:0])
      2'b00: begin ih = ip; oh = ~oh; end
      2'b01: return (c == 36'd0) ? 36'd1 : st36(c);
      2'b10: return st36(c) ^ pin;
      default: begin
        ih = st18(ih) ^ ip;
        if (op[2]) oh = oh + 18'd1;
        else       oh = (oh == 18'd0) ? 18'd1 : st18(oh);
      end
    endcase
    return fwd ? {oh, ih} : {ih, oh};
  endfunction

  function automatic string tag_of(logic run, logic [2:0] op, logic [1:0] ab, logic [1:0] ba);
    if (!run || !dir_valid(ab, ba)) return "R2";
    case (op[1:0])
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R6";
      default: return op[2] ? "R8" : "R7";
    endcase
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] oe_expect(logic [1:0] ab, logic [1:0] ba);
    return {{9{ab[1]}}, {9{ab[0]}}, {9{ba[1]}}, {9{ba[0]}}};
  endfunction

  task automatic apply(logic run, logic [2:0] op, logic [1:0] ab, logic [1:0] ba, logic [35:0] pin);
    run_idle = run; opcode = op; ab_en = ab; ba_en = ba; pin_in = pin;
  endtask

  task automatic step_and_check(string req);
    logic [35:0] exp = mnext(model, run_idle, opcode, ab_en, ba_en, pin_in);
    @(posedge tck); #1;
    model = exp;
    check(req, cell_q, model);
    @(negedge tck); #1;
    check("R9", pin_out, model);
    check("R10", pin_oe, oe_expect(ab_en, ba_en));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge tck);
    #1;
    model = '0;
    check("R1", cell_q, 36'd0);
    check("R1", pin_out, 36'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    apply(1'b1, 3'b001, 2'b11, 2'b00, 36'h0);
    do_reset();

    // table walk: model-predicted state after every edge
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][43], VEC[i][42:40], VEC[i][39:38], VEC[i][37:36], VEC[i][35:0]);
      step_and_check(tag_of(VEC[i][43], VEC[i][42:40], VEC[i][39:38], VEC[i][37:36]));
    end

    // R5: full generator from zero seeds to 1
    apply(1'b0, 3'b000, 2'b11, 2'b00, 36'h0);
    do_reset();
    apply(1'b1, 3'b001, 2'b11, 2'b00, 36'h0);
    step_and_check("R5");
    check("R5", cell_q, 36'd1);

    // R5/R7: half generator from zero seeds to 1 in output half (B side)
    apply(1'b0, 3'b000, 2'b11, 2'b00, 36'h0);
    do_reset();
    apply(1'b1, 3'b011, 2'b11, 2'b00, 36'h0);
    step_and_check("R7");
    check("R7", cell_q, 36'h1 << 18);

    // R8: counter wrap from all ones to zero
    apply(1'b0, 3'b000, 2'b11, 2'b00, 36'h0);
    do_reset();
    apply(1'b1, 3'b000, 2'b11, 2'b00, 36'h0);
    step_and_check("R3");
    check("R3", cell_q, {18'h3FFFF, 18'h0});
    apply(1'b1, 3'b111, 2'b11, 2'b00, 36'h0);
    step_and_check("R8");
    check("R8", cell_q, 36'h0);

    // R2: neither enable on a lane holds; R10 oe all low
    apply(1'b1, 3'b000, 2'b00, 2'b00, 36'hFFFFFFFFF);
    step_and_check("R2");
    check("R2", cell_q, 36'h0);
    check("R10", pin_oe, 36'h0);

    // R1: reset in the middle of activity
    apply(1'b1, 3'b000, 2'b11, 2'b00, 36'h0);
    step_and_check("R3");
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule